// File: doc/BRIEF.md
# Synchronous DRAM Column Burst Data Path

This block is the device-side column engine for a single open row of a synchronous DRAM. It watches the command pins, and on a read or write it takes the column given with the command as the first address of a burst. From then on it steps through consecutive columns one per clock. The steps wrap inside the aligned block whose size is the programmed burst length, so a burst that starts mid-block still moves exactly that many words. Read data leaves the block after the programmed CAS latency. Write data is taken from the very cycle of the write command. The row itself is a small register array inside the block.

The data mask pin acts with two different delays. For reads it silences the output bus two clocks after it is sampled. For writes it blocks the beat of the same clock. A new read or write cuts the running burst short, and back-to-back reads keep the output stream free of gaps. A burst stop command ends a burst at once, and it is the only way to end a full-page burst. Burst length and CAS latency are plain mode inputs. Bank timing is left to the surrounding logic. The output bus is modelled as a data word plus a separate drive-enable rather than a real three-state pin.

Top module: `sdr_burst_path`

## Requirements
- R1: With `cl` set to 1, 2 or 3, the first word of a read burst is driven (`dout_oe` high) in the clock cycle that ends at the `cl`-th rising edge after the edge that sampled the read command. Each later word follows one cycle after the previous one.
- R2: A write stores `din` of the command edge at the command column, and stores `din` of each following edge at the next burst column, one word per clock.
- R3: `bl_code` selects the burst length: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page of 2^COL_W words. Beat i of a burst starting at column c uses column (c with its low log2(BL) bits cleared) OR ((c+i) mod BL), so exactly BL words move.
- R4: `dout_oe` is low and `dout` is zero in every cycle that carries no unmasked read word. A read issued while an earlier read is still running continues the output with no idle cycle between the two bursts.
- R5: A `dqm` value of 1 sampled at rising edge m forces `dout_oe` low for the cycle that follows edge m+1. During a write, `dqm` of 1 at an edge leaves the array word for that beat unchanged.
- R6: A new read or write command ends the running burst at once, so no further beat of the old burst is read or written. A write command also discards read words still in flight, and the bus stays undriven.
- R7: A burst stop command ends the running burst at its edge, and the stop edge itself moves no data. Read words issued before the stop still appear. A full-page burst that is not stopped keeps wrapping through the row.
- R8: With `cs_n` low, the command pins {`ras_n`,`cas_n`,`we_n`} decode as 101 = read, 100 = write and 110 = burst stop. Every other pattern, and any pattern with `cs_n` high, moves no data.
- R9: While `rst_n` is low, `dout_oe` is low, no burst is active and every array word is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write enable command pin |
| col | input | COL_W | Start column for read and write commands |
| dqm | input | 1 | Data mask |
| din | input | DATA_W | Write data |
| bl_code | input | 3 | Burst length code (R3) |
| cl | input | CL_W | CAS latency, 1 to MAX_CL |
| dout | output | DATA_W | Read data, zero while not driven |
| dout_oe | output | 1 | Read data drive enable |

## Verification
Reads are run at every burst length and every latency. Some start on a block boundary and some start mid-block, so a wrong wrap, a wrong count or a latency that is off by one each lands on a different checked cycle. Writes are run with mask patterns that skip chosen beats and with columns that wrap, and the results are read back so that masked and unmasked beats can be told apart. Interrupt sequences are also run: read over read, write over read, read over write, and a stop partway through a burst. These show whether the old burst really ends, whether in-flight data is kept or discarded, and whether the hand-over leaves a gap. A pass of decoy pin patterns confirms that non-commands move nothing.

// File: rtl/sdr_burst_pkg.sv
// Shared definitions for the column burst data path.
// Assumes: command decode needs only four outcomes.
package sdr_burst_pkg;
    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_STOP  = 2'd3
    } cmd_e;

    localparam logic [2:0] BL_FULL = 3'd7;
endpackage

// File: rtl/sdr_cmd_decode.sv
// Turns the four command pins into a column-path command.
// Assumes: row and bank commands are handled elsewhere and count as no-ops here.
module sdr_cmd_decode
    import sdr_burst_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    // Decode the selected pin pattern; a deselected chip is a no-op.
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                3'b110:  cmd = CMD_STOP;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdr_col_gen.sv
// Column sequencer: produces one beat per clock with wrap inside the burst block.
// Assumes: COL_W >= 3 so that a burst of eight fits; a command beat uses the pins' column directly.
module sdr_col_gen
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic [COL_W-1:0] col,
    input  logic [2:0]       bl_code,
    output logic             beat_vld,
    output logic             beat_wr,
    output logic [COL_W-1:0] beat_col
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] nxt_col;
    logic [COL_W-1:0] cur_q;
    logic [COL_W-1:0] left_q;
    logic             act_q;
    logic             wr_q;
    logic             full_page;

    // Block mask from the burst length code (BL minus one).
    always_comb begin
        case (bl_code)
            3'd1:    mask = COL_W'(1);
            3'd2:    mask = COL_W'(3);
            3'd3:    mask = COL_W'(7);
            BL_FULL: mask = '1;
            default: mask = '0;
        endcase
    end

    assign full_page = (bl_code == BL_FULL);

    // Beat of the current cycle: a command beat wins over a running burst.
    always_comb begin
        beat_vld = act_q;
        beat_wr  = wr_q;
        beat_col = cur_q;
        if (cmd == CMD_READ || cmd == CMD_WRITE) begin
            beat_vld = 1'b1;
            beat_wr  = (cmd == CMD_WRITE);
            beat_col = col;
        end else if (cmd == CMD_STOP) begin
            beat_vld = 1'b0;
        end
    end

    // Next column keeps the block bits and wraps the low bits.
    assign nxt_col = (beat_col & ~mask) | ((beat_col + COL_W'(1)) & mask);

    // Burst state: start, advance, count down, or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            wr_q   <= 1'b0;
            cur_q  <= '0;
            left_q <= '0;
        end else begin
            case (cmd)
                CMD_READ, CMD_WRITE: begin
                    act_q  <= (mask != '0);
                    wr_q   <= (cmd == CMD_WRITE);
                    cur_q  <= nxt_col;
                    left_q <= mask;
                end
                CMD_STOP: begin
                    act_q <= 1'b0;
                end
                default: begin
                    if (act_q) begin
                        cur_q <= nxt_col;
                        if (!full_page) begin
                            left_q <= left_q - COL_W'(1);
                            if (left_q == COL_W'(1)) begin
                                act_q <= 1'b0;
                            end
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sdr_rd_pipe.sv
// Read latency pipeline with the two-clock output mask.
// Assumes: cl of 0 acts as 1 and values above MAX_CL act as MAX_CL; flush drops all in-flight words.
module sdr_rd_pipe #(
    parameter int DATA_W = 16,
    parameter int MAX_CL = 3,
    parameter int CL_W   = $clog2(MAX_CL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] issue_data,
    input  logic              flush,
    input  logic              dqm,
    input  logic [CL_W-1:0]   cl,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    logic [MAX_CL:1]   vld_q;
    logic [DATA_W-1:0] dat_q [1:MAX_CL];
    logic [1:0]        dqm_q;
    logic [CL_W-1:0]   sel;

    // First stage captures the word fetched at the issue edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[1] <= 1'b0;
            dat_q[1] <= '0;
        end else begin
            vld_q[1] <= issue & ~flush;
            dat_q[1] <= issue_data;
        end
    end

    // Later stages shift the word along, one per clock.
    for (genvar j = 2; j <= MAX_CL; j++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[j] <= 1'b0;
                dat_q[j] <= '0;
            end else begin
                vld_q[j] <= vld_q[j-1] & ~flush;
                dat_q[j] <= dat_q[j-1];
            end
        end
    end

    // Mask history: bit 1 holds the value sampled two edges back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dqm_q <= '0;
        end else begin
            dqm_q <= {dqm_q[0], dqm};
        end
    end

    // Pick the stage that matches the latency and gate with the delayed mask.
    always_comb begin
        if (cl == '0) begin
            sel = CL_W'(1);
        end else if (cl > CL_W'(MAX_CL)) begin
            sel = CL_W'(MAX_CL);
        end else begin
            sel = cl;
        end
        dout_oe = vld_q[sel] & ~dqm_q[1];
        dout    = dout_oe ? dat_q[sel] : '0;
    end
endmodule

// File: rtl/sdr_burst_path.sv
// Top of the column burst data path: decode, column sequencing, row storage, read pipeline.
// Assumes: one open row of 2^COL_W words; bank timing is met by the caller.
module sdr_burst_path
    import sdr_burst_pkg::*;
#(
    parameter int  COL_W  = 5,
    parameter int  DATA_W = 16,
    parameter int  MAX_CL = 3,
    localparam int CL_W   = $clog2(MAX_CL + 1),
    localparam int DEPTH  = 1 << COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [COL_W-1:0]  col,
    input  logic              dqm,
    input  logic [DATA_W-1:0] din,
    input  logic [2:0]        bl_code,
    input  logic [CL_W-1:0]   cl,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    cmd_e              cmd;
    logic              beat_vld;
    logic              beat_wr;
    logic [COL_W-1:0]  beat_col;
    logic [DATA_W-1:0] mem_q [DEPTH];

    sdr_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdr_col_gen #(.COL_W(COL_W)) u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .col      (col),
        .bl_code  (bl_code),
        .beat_vld (beat_vld),
        .beat_wr  (beat_wr),
        .beat_col (beat_col)
    );

    // Row storage: clear on reset, unmasked write beats store din.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (beat_vld && beat_wr && !dqm) begin
            mem_q[beat_col] <= din;
        end
    end

    sdr_rd_pipe #(.DATA_W(DATA_W), .MAX_CL(MAX_CL), .CL_W(CL_W)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (beat_vld & ~beat_wr),
        .issue_data (mem_q[beat_col]),
        .flush      (cmd == CMD_WRITE),
        .dqm        (dqm),
        .cl         (cl),
        .dout       (dout),
        .dout_oe    (dout_oe)
    );
endmodule

// File: rtl/sdr_burst_chk.sv
// Property checker for the column burst data path, bound to the top.
// Assumes: the internal command and beat signals of the top are visible by name.
module sdr_burst_chk
    import sdr_burst_pkg::*;
#(
    parameter int COL_W  = 5,
    parameter int DATA_W = 16,
    parameter int CL_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input cmd_e              cmd,
    input logic              dqm,
    input logic [CL_W-1:0]   cl,
    input logic [2:0]        bl_code,
    input logic              beat_vld,
    input logic [COL_W-1:0]  beat_col,
    input logic              dout_oe,
    input logic [DATA_W-1:0] dout
);
    logic [COL_W-1:0] blk;

    // Independent block mask used by the wrap property.
    always_comb begin
        case (bl_code)
            3'd1:    blk = COL_W'(1);
            3'd2:    blk = COL_W'(3);
            3'd3:    blk = COL_W'(7);
            BL_FULL: blk = '1;
            default: blk = '0;
        endcase
    end

    // R4: an undriven bus carries zero.
    p_idle_bus_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> dout == '0);

    // R1: at latency one a read word shows one edge after the command.
    p_first_beat_cl1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cl == CL_W'(1) && $past(cl) == CL_W'(1) && $past(rst_n) && $past(rst_n, 2)
         && $past(cmd) == CMD_READ && !$past(dqm, 2)) |-> dout_oe);

    // R5: a read mask sampled two edges back silences the bus.
    p_read_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(dqm, 2)) |-> !dout_oe);

    // R6: a write command discards read words in flight.
    p_write_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WRITE) |=> !dout_oe);

    // R3: a running burst stays inside its aligned block.
    p_wrap_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && cmd == CMD_NOP && $past(rst_n) && $past(beat_vld) && $stable(bl_code))
        |-> ((beat_col & ~blk) == ($past(beat_col) & ~blk)));

    // R7: after a stop no burst beat runs unless a new command starts one.
    p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STOP) |=> (!beat_vld || cmd != CMD_NOP));
endmodule

bind sdr_burst_path sdr_burst_chk #(
    .COL_W  (COL_W),
    .DATA_W (DATA_W),
    .CL_W   (CL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .dqm      (dqm),
    .cl       (cl),
    .bl_code  (bl_code),
    .beat_vld (beat_vld),
    .beat_col (beat_col),
    .dout_oe  (dout_oe),
    .dout     (dout)
);

// File: tb/sim_sdr_burst_path.sv
// Directed bench for the column burst data path; one task per scenario.
module sim_sdr_burst_path;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 5;
    localparam int DATA_W     = 16;
    localparam int DEPTH      = 1 << COL_W;
    localparam int WDOG       = 20000;
    localparam logic [2:0] BLF = 3'd7;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cs_n, ras_n, cas_n, we_n;
    logic [COL_W-1:0]  col;
    logic              dqm;
    logic [DATA_W-1:0] din;
    logic [2:0]        bl_code;
    logic [1:0]        cl;
    logic [DATA_W-1:0] dout;
    logic              dout_oe;

    int                n_cmp = 0;
    int                n_bad = 0;
    bit                done  = 1'b0;
    logic [DATA_W-1:0] model [DEPTH];

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdr_burst_path u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .col(col), .dqm(dqm), .din(din), .bl_code(bl_code),
        .cl(cl), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_pins(input logic c, input logic r, input logic a, input logic w);
        cs_n = c; ras_n = r; cas_n = a; we_n = w;
    endtask

    task automatic set_nop();  set_pins(1'b0, 1'b1, 1'b1, 1'b1); endtask
    task automatic set_stop(); set_pins(1'b0, 1'b1, 1'b1, 1'b0); endtask
    task automatic set_rd(input logic [COL_W-1:0] c);
        set_pins(1'b0, 1'b1, 1'b0, 1'b1); col = c;
    endtask
    task automatic set_wr(input logic [COL_W-1:0] c, input logic [DATA_W-1:0] d);
        set_pins(1'b0, 1'b1, 1'b0, 1'b0); col = c; din = d;
    endtask

    function automatic int blen(input logic [2:0] code);
        case (code)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            default: return DEPTH;
        endcase
    endfunction

    function automatic logic [COL_W-1:0] wadr(input logic [COL_W-1:0] c, input int i, input int len);
        logic [COL_W-1:0] m;
        m = COL_W'(len - 1);
        return (c & ~m) | (COL_W'(int'(c) + i) & m);
    endfunction

    // Read burst with optional per-beat read mask; full page is ended by a stop after BL beats.
    task automatic rd_burst(input logic [COL_W-1:0] c, input logic [2:0] code, input int clv,
                            input logic [31:0] dm, input string req);
        int len;
        len = blen(code);
        bl_code = code;
        cl = clv[1:0];
        for (int s = 0; s <= clv + len; s++) begin
            if (s > 0) begin
                int b;
                b = s - clv;
                if (b >= 0 && b < len) begin
                    chk(req, {31'b0, dout_oe}, {31'b0, !dm[b]});
                    if (!dm[b]) chk(req, {16'b0, dout}, {16'b0, model[wadr(c, b, len)]});
                end else begin
                    chk(req, {31'b0, dout_oe}, 32'd0);
                end
            end
            if (s < clv + len) begin
                int j;
                j = s - clv + 2;
                if (s == 0) set_rd(c);
                else if (code == BLF && s == len) set_stop();
                else set_nop();
                dqm = (j >= 0 && j < len) ? dm[j] : 1'b0;
                step();
            end
        end
        set_nop();
        dqm = 1'b0;
    endtask

    // Write burst with per-beat write mask; a trailing word is offered and must be ignored.
    task automatic wr_burst(input logic [COL_W-1:0] c, input logic [2:0] code,
                            input logic [DATA_W-1:0] base, input logic [31:0] dm);
        int len;
        len = blen(code);
        bl_code = code;
        for (int i = 0; i < len; i++) begin
            logic [DATA_W-1:0] d;
            d = base + DATA_W'(i);
            if (i == 0) set_wr(c, d);
            else begin set_nop(); din = d; end
            dqm = dm[i];
            step();
            if (!dm[i]) model[wadr(c, i, len)] = d;
        end
        if (code == BLF) set_stop(); else set_nop();
        din = 16'hDEAD;
        dqm = 1'b0;
        step();
        set_nop();
        step();
    endtask

    task automatic t_reset();
        chk("R9 oe in reset", {31'b0, dout_oe}, 32'd0);
        chk("R9 dout in reset", {16'b0, dout}, 32'd0);
    endtask

    task automatic t_basic_reads();
        rd_burst(5'd5, 3'd0, 1, 32'd0, "R9/R1 cleared word at cl1");
        wr_burst(5'd0, BLF, 16'h1000, 32'd0);
        rd_burst(5'd0, 3'd3, 2, 32'd0, "R2/R1 aligned bl8 cl2");
        rd_burst(5'd6, 3'd2, 2, 32'd0, "R3 bl4 wrap from 6");
        rd_burst(5'd13, 3'd3, 3, 32'd0, "R3/R1 bl8 wrap cl3");
        rd_burst(5'd9, 3'd1, 1, 32'd0, "R3 bl2 odd start cl1");
        rd_burst(5'd30, BLF, 2, 32'd0, "R7/R3 full page wrap and stop");
    endtask

    task automatic t_write_mask();
        wr_burst(5'd10, 3'd2, 16'hA0A0, 32'b0101);
        rd_burst(5'd8, 3'd2, 2, 32'd0, "R5 write mask keeps beats");
        wr_burst(5'd21, 3'd3, 16'hB000, 32'd0);
        rd_burst(5'd16, 3'd3, 3, 32'd0, "R2/R3 write wrap bl8");
    endtask

    task automatic t_read_mask();
        rd_burst(5'd0, 3'd2, 2, 32'b0100, "R5 read mask beat 2 cl2");
        rd_burst(5'd4, 3'd2, 3, 32'b1001, "R5 read mask beats 0 and 3 cl3");
    endtask

    task automatic t_gapless();
        bl_code = 3'd2;
        cl = 2'd2;
        for (int s = 0; s <= 8; s++) begin
            if (s >= 2 && s < 4) begin
                chk("R4/R6 gapless first", {31'b0, dout_oe}, 32'd1);
                chk("R4/R6 gapless first data", {16'b0, dout}, {16'b0, model[wadr(5'd0, s - 2, 4)]});
            end else if (s >= 4 && s < 8) begin
                chk("R4/R6 gapless second", {31'b0, dout_oe}, 32'd1);
                chk("R4/R6 gapless second data", {16'b0, dout}, {16'b0, model[wadr(5'd16, s - 4, 4)]});
            end else if (s == 8) begin
                chk("R4 bus idle after burst", {31'b0, dout_oe}, 32'd0);
            end
            if (s < 8) begin
                if (s == 0) set_rd(5'd0);
                else if (s == 2) set_rd(5'd16);
                else set_nop();
                step();
            end
        end
        set_nop();
    endtask

    task automatic t_write_cuts_read();
        bl_code = 3'd3;
        cl = 2'd3;
        for (int s = 0; s <= 6; s++) begin
            if (s >= 1) chk("R6 write discards read", {31'b0, dout_oe}, 32'd0);
            if (s < 6) begin
                if (s == 0) set_rd(5'd0);
                else if (s == 1) begin set_wr(5'd20, 16'hC0DE); bl_code = 3'd0; end
                else begin set_nop(); din = 16'h9999; end
                step();
            end
        end
        set_nop();
        model[20] = 16'hC0DE;
        rd_burst(5'd16, 3'd3, 2, 32'd0, "R6 single write after cut");
    endtask

    task automatic t_read_cuts_write();
        bl_code = 3'd3;
        cl = 2'd2;
        for (int s = 0; s <= 13; s++) begin
            if (s >= 1 && s < 5) chk("R6 idle before read", {31'b0, dout_oe}, 32'd0);
            if (s >= 5 && s < 13) begin
                chk("R6 read after cut write", {31'b0, dout_oe}, 32'd1);
                chk("R6 read after cut write data", {16'b0, dout}, {16'b0, model[24 + s - 5]});
            end
            if (s == 13) chk("R4 idle after read", {31'b0, dout_oe}, 32'd0);
            if (s < 13) begin
                if (s == 0) set_wr(5'd24, 16'h6600);
                else if (s < 3) begin set_nop(); din = 16'h6600 + DATA_W'(s); end
                else if (s == 3) begin set_rd(5'd24); din = 16'hFFFF; end
                else begin set_nop(); din = 16'hFFFF; end
                step();
                if (s < 3) model[24 + s] = 16'h6600 + DATA_W'(s);
            end
        end
        set_nop();
    endtask

    task automatic t_stop_write();
        bl_code = BLF;
        for (int s = 0; s < 7; s++) begin
            if (s == 0) set_wr(5'd8, 16'h5500);
            else if (s < 3) begin set_nop(); din = 16'h5500 + DATA_W'(s); end
            else if (s == 3) begin set_stop(); din = 16'hEEEE; end
            else begin set_nop(); din = 16'hEEEE; end
            step();
            if (s < 3) model[8 + s] = 16'h5500 + DATA_W'(s);
        end
        set_nop();
        rd_burst(5'd8, 3'd3, 2, 32'd0, "R7 stop ends full-page write");
    endtask

    task automatic t_decode();
        bl_code = 3'd0;
        cl = 2'd1;
        for (int s = 0; s <= 5; s++) begin
            if (s >= 1) chk("R8 non-command drives nothing", {31'b0, dout_oe}, 32'd0);
            if (s < 5) begin
                if (s == 0) begin set_pins(1'b1, 1'b1, 1'b0, 1'b1); col = 5'd3; end
                else if (s == 1) set_pins(1'b0, 1'b0, 1'b1, 1'b1);
                else if (s == 2) begin set_pins(1'b1, 1'b1, 1'b0, 1'b0); col = 5'd3; din = 16'h7777; end
                else set_nop();
                step();
            end
        end
        set_nop();
        rd_burst(5'd3, 3'd0, 1, 32'd0, "R8 deselected write stored nothing");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        rst_n = 1'b0;
        set_nop();
        col = '0;
        dqm = 1'b0;
        din = '0;
        bl_code = 3'd0;
        cl = 2'd1;
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_basic_reads();
        t_write_mask();
        t_read_mask();
        t_gapless();
        t_write_cuts_read();
        t_read_cuts_write();
        t_stop_write();
        t_decode();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule